// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Logic

This block assembles an instrument's status byte from summary flags delivered by lower status registers and from a flag that says the output message queue holds a response. Operation summary, event summary, message-available and questionable summary are captured into the byte on every clock edge. A host-writable enable mask selects which of those bits feed a master summary. That summary is reported in bit 6 of the byte returned to a status query.

A rising master summary arms a request-service flag, which drives the service-request line. A serial poll returns the same byte with the request-service flag in bit 6 in place of the master summary, and the poll clears that flag. A clear-status strobe drops every captured summary except message-available and withdraws a pending request. It leaves the enable mask alone. Power-on reset clears everything.

Top module: `srq_status_core`

## Requirements
- R1: One clock edge after sampling, the query byte `stat_byte_o` holds operation summary in bit 7, event summary in bit 5, message-available (queue not empty) in bit 4 and questionable summary in bit 3. Bits 2..0 always read 0.
- R2: Bit 6 of `stat_byte_o` (master summary) is 1 exactly when any of bits 7, 5, 4, 3 of the byte is 1 and the same bit of the enable mask is 1. It follows a mask change in the same cycle the new mask appears on `mask_o`.
- R3: On `mask_wr_i`, the mask takes `mask_wdata_i` with bit 6 forced to 0 and reads back on `mask_o` after the edge. A write value above `MASK_LIMIT` (default 191) is ignored, and the mask keeps its old value.
- R4: While `rst_n` is low, `stat_byte_o`, `poll_byte_o` and `mask_o` read 0 and `srq_o` is 0.
- R5: A `clr_stat_i` cycle clears bits 7, 5 and 3 and the request-service flag at that edge. Bit 4 still follows the queue flag. The mask is unchanged. Summary bits reload from the inputs on the next edge.
- R6: One edge after master summary goes from 0 to 1, the request-service flag is set, and `srq_o` equals that flag. If master summary stays 1, the flag is not set again.
- R7: `poll_byte_o` equals `stat_byte_o` except that bit 6 carries the request-service flag. A `poll_i` cycle clears the flag at that edge. Clear-status wins over a new rise, and a new rise wins over a poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| oper_sum_i | input | 1 | Operation summary from the operation register |
| esb_i | input | 1 | Event summary from the event register |
| queue_nonempty_i | input | 1 | Output message queue holds data |
| ques_sum_i | input | 1 | Questionable summary from the questionable register |
| clr_stat_i | input | 1 | Clear-status strobe |
| mask_wr_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 8 | Enable mask write data |
| poll_i | input | 1 | Serial poll read strobe |
| stat_byte_o | output | 8 | Status byte for a query read (master summary in bit 6) |
| poll_byte_o | output | 8 | Status byte for a serial poll read (request service in bit 6) |
| mask_o | output | 8 | Enable mask readback |
| srq_o | output | 1 | Service request line |

## Verification
The bench builds the block with its default `MASK_LIMIT` of 191. That value puts the write boundary between 191 and 192 within reach of directed writes, and it lets mask values in the 64 to 127 range show bit 6 being dropped while the write is still accepted. A vector walk pairs each mask with summary patterns, so every status bit gates master summary both alone and alongside unmasked bits. Directed sequences then exercise the request-service flag: arming on a rise, clearing on a poll, staying quiet while master summary stays high, and being cancelled by clear-status.

// File: rtl/srq_status_core.sv
module srq_status_core #(
  parameter logic [7:0] MASK_LIMIT = 8'd191
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oper_sum_i,
  input  logic       esb_i,
  input  logic       queue_nonempty_i,
  input  logic       ques_sum_i,
  input  logic       clr_stat_i,
  input  logic       mask_wr_i,
  input  logic [7:0] mask_wdata_i,
  input  logic       poll_i,
  output logic [7:0] stat_byte_o,
  output logic [7:0] poll_byte_o,
  output logic [7:0] mask_o,
  output logic       srq_o
);

  logic       oss_q, esb_q, mav_q, qss_q;
  logic [7:0] mask_q;
  logic       mss, mss_q, rqs_q;
  logic [7:0] sum_bits;

  assign sum_bits = {oss_q, 1'b0, esb_q, mav_q, qss_q, 3'b000};
  assign mss      = |(sum_bits & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oss_q <= 1'b0;
      esb_q <= 1'b0;
      qss_q <= 1'b0;
      mav_q <= 1'b0;
    end else begin
      oss_q <= oper_sum_i & ~clr_stat_i;
      esb_q <= esb_i      & ~clr_stat_i;
      qss_q <= ques_sum_i & ~clr_stat_i;
      mav_q <= queue_nonempty_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= 8'h00;
    else if (mask_wr_i && mask_wdata_i <= MASK_LIMIT)
      mask_q <= mask_wdata_i & 8'hBF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mss_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      mss_q <= mss;
      if (clr_stat_i)
        rqs_q <= 1'b0;
      else if (mss && !mss_q)
        rqs_q <= 1'b1;
      else if (poll_i)
        rqs_q <= 1'b0;
    end
  end

  assign stat_byte_o = sum_bits | {1'b0, mss,   6'b0};
  assign poll_byte_o = sum_bits | {1'b0, rqs_q, 6'b0};
  assign mask_o      = mask_q;
  assign srq_o       = rqs_q;

endmodule

module srq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       queue_nonempty_i,
  input logic       clr_stat_i,
  input logic       mask_wr_i,
  input logic       poll_i,
  input logic [7:0] stat_byte_o,
  input logic [7:0] poll_byte_o,
  input logic [7:0] mask_o,
  input logic       srq_o
);

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte_o[2:0] == 3'b000); // R1

  AST_MASK_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_o[6] == 1'b0); // R3

  AST_MSS_FROM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte_o[6] == |(stat_byte_o & mask_o & 8'hB8)); // R2

  AST_CLR_KEEPS_MAV: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat_i |=> (stat_byte_o[7] == 1'b0 && stat_byte_o[5] == 1'b0 &&
                    stat_byte_o[3] == 1'b0 && !srq_o &&
                    stat_byte_o[4] == $past(queue_nonempty_i))); // R5

  AST_CLR_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat_i && !mask_wr_i) |=> $stable(mask_o)); // R5

  AST_RISE_SETS_RQS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_stat_i && stat_byte_o[6] && !$past(stat_byte_o[6])) |=> srq_o); // R6

  AST_POLL_CLEARS_RQS: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_i && !clr_stat_i && !(stat_byte_o[6] && !$past(stat_byte_o[6]))) |=> !srq_o); // R7

  AST_POLL_BYTE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_byte_o & 8'hBF) == (stat_byte_o & 8'hBF)); // R7

endmodule

bind srq_status_core srq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .queue_nonempty_i(queue_nonempty_i),
  .clr_stat_i(clr_stat_i), .mask_wr_i(mask_wr_i), .poll_i(poll_i),
  .stat_byte_o(stat_byte_o), .poll_byte_o(poll_byte_o),
  .mask_o(mask_o), .srq_o(srq_o)
);

// File: tb/sim_srq_status_core.sv
`timescale 1ns/1ps
module sim_srq_status_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oper = 1'b0, esb = 1'b0, mav = 1'b0, ques = 1'b0;
  logic       clr = 1'b0, mwr = 1'b0, poll = 1'b0;
  logic [7:0] mdata = 8'h00;
  logic [7:0] stat_b, poll_b, mask_r;
  logic       srq;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  srq_status_core u0 (
    .clk(clk), .rst_n(rst_n), .oper_sum_i(oper), .esb_i(esb),
    .queue_nonempty_i(mav), .ques_sum_i(ques), .clr_stat_i(clr),
    .mask_wr_i(mwr), .mask_wdata_i(mdata), .poll_i(poll),
    .stat_byte_o(stat_b), .poll_byte_o(poll_b), .mask_o(mask_r), .srq_o(srq)
  );

  // {mask, oper, esb, mav, ques, expected query byte}
  localparam logic [19:0] VEC [10] = '{
    {8'h00, 4'b0000, 8'h00},
    {8'h00, 4'b1111, 8'hB8},
    {8'h80, 4'b1000, 8'hC0},
    {8'h20, 4'b0100, 8'h60},
    {8'h10, 4'b0010, 8'h50},
    {8'h08, 4'b0001, 8'h48},
    {8'h08, 4'b1110, 8'hB0},
    {8'hBF, 4'b0000, 8'h00},
    {8'h07, 4'b1111, 8'hB8},
    {8'h30, 4'b0110, 8'h70}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R4 reset query byte", stat_b, 8'h00);
    chk("R4 reset poll byte", poll_b, 8'h00);
    chk("R4 reset mask", mask_r, 8'h00);
    chk("R4 reset srq", {7'b0, srq}, 8'h00);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 10; i++) begin
      mwr = 1'b1;
      mdata = VEC[i][19:12];
      {oper, esb, mav, ques} = VEC[i][11:8];
      tick();
      mwr = 1'b0;
      chk($sformatf("R1 R2 vector %0d", i), stat_b, VEC[i][7:0]);
    end

    // R3 mask writes
    {oper, esb, mav, ques} = 4'b0000;
    clr = 1'b1; tick(); clr = 1'b0;
    mwr = 1'b1; mdata = 8'h7F; tick();
    chk("R3 bit6 dropped", mask_r, 8'h3F);
    mdata = 8'hC0; tick();
    chk("R3 write above limit ignored", mask_r, 8'h3F);
    mdata = 8'hBF; tick();
    mwr = 1'b0;
    chk("R3 write at limit", mask_r, 8'hBF);

    // R5 clear-status
    mwr = 1'b1; mdata = 8'h00; {oper, esb, mav, ques} = 4'b1111; tick(); mwr = 1'b0;
    chk("R1 all summaries", stat_b, 8'hB8);
    mwr = 1'b1; mdata = 8'h80; tick(); mwr = 1'b0;
    clr = 1'b1; tick(); clr = 1'b0;
    chk("R5 clear keeps only MAV", stat_b, 8'h10);
    chk("R5 clear keeps mask", mask_r, 8'h80);
    chk("R5 clear drops srq", {7'b0, srq}, 8'h00);
    tick();
    chk("R5 reload after clear", stat_b, 8'hF8);

    // R6 R7 request service
    {oper, esb, mav, ques} = 4'b0000;
    mwr = 1'b1; mdata = 8'h10; tick(); mwr = 1'b0;
    clr = 1'b1; tick(); clr = 1'b0;
    tick();
    chk("R6 idle srq", {7'b0, srq}, 8'h00);
    mav = 1'b1; tick();
    chk("R2 mss up", stat_b, 8'h50);
    chk("R6 srq not yet", {7'b0, srq}, 8'h00);
    tick();
    chk("R6 srq set after rise", {7'b0, srq}, 8'h01);
    chk("R7 poll byte shows rqs", poll_b, 8'h50);
    poll = 1'b1; tick(); poll = 1'b0;
    chk("R7 poll clears srq", {7'b0, srq}, 8'h00);
    chk("R7 poll byte bit6 clear", poll_b, 8'h10);
    chk("R7 query byte keeps mss", stat_b, 8'h50);
    repeat (3) tick();
    chk("R6 no re-request while mss high", {7'b0, srq}, 8'h00);
    mav = 1'b0; tick(); mav = 1'b1; tick(); tick();
    chk("R6 new rise sets srq", {7'b0, srq}, 8'h01);
    clr = 1'b1; tick(); clr = 1'b0;
    chk("R5 clear withdraws srq", {7'b0, srq}, 8'h00);

    // R4 power-on reset mid run
    rst_n = 1'b0; @(negedge clk);
    chk("R4 reset clears mask", mask_r, 8'h00);
    chk("R4 reset clears byte", stat_b, 8'h00);
    rst_n = 1'b1; tick();

    finish_run();
  end

endmodule